// File: doc/BRIEF.md
# UART Receive-Idle Interrupt Controller

This block collects the interrupt sources of a UART whose receive and transmit FIFOs are drained and filled by a DMA engine. It ranks the sources, presents the winner as a 3-bit identification code with a "nothing pending" flag, and drives a single interrupt line. It watches two receive conditions that plain level triggers miss.

The first is a receive timeout. It fires when the line has gone quiet and the receive FIFO holds a byte count that is not a multiple of the DMA word size, so word-aligned DMA can never empty it. The second is an end-of-data event. It fires once after the line has paused for four character times following received data, and it tells software that a burst has finished.

Character timing comes from a tick that runs at 16 times the bit rate. A character is counted as a fixed number of bits. Serial shifters, the baud generator and the DMA engine are separate blocks. They feed this one with FIFO levels, a character strobe and error and modem-change flags.

Top module: `uart_rx_irq_ctrl`

## Requirements
- R1: After a synchronous reset, `iir` reads 4'b0001 (bit 0 = 1 means nothing pending, code 0), `irq` is 0 and `eod_status` is 0.
- R2: `iir[3:1]` carries the code of the presented source, and `iir[0]` is 1 only when no enabled source is pending. `irq` is 1 exactly when `iir[0]` is 0.
- R3: Any bit of `line_err` latches a line-error condition (code 3). It stays latched until a `lsr_rd` pulse that arrives with `line_err` all zero.
- R4: A receive-data condition (code 2) is pending while `rx_level` is 4 or more.
- R5: A receive-timeout condition (code 6) is pending while the line is idle and `rx_level` is not a multiple of 4 (its two low bits are non-zero). It drops as soon as the level becomes aligned.
- R6: The line counts as idle once 640 `tick` pulses have arrived with no `rx_char_stb` (4 characters × 10 bits × 16 ticks). Only cycles with `tick` high advance the count. The first time the line goes idle after a character, `eod_status` sets and end of data (code 4) becomes pending.
- R7: When a pause follows a misaligned amount of data, timeout (code 6) is presented before end of data (code 4). End of data appears once the level becomes aligned.
- R8: End of data clears when `iir_rd` pulses while `iir` shows code 4 with bit 0 = 0, or when `rx_char_stb` pulses.
- R9: A transmit-empty condition (code 1) is pending while `tx_level` is 16 or less.
- R10: A modem condition (code 0, with `iir[0]` = 0) is pending while any bit of `modem_delta` is set.
- R11: Enable bits in `ier`: bit0 receive data, bit1 transmit empty, bit2 line error, bit3 modem, bit4 timeout, bit5 end of data. A source whose bit is 0 never appears in `iir` and does not raise `irq`. `eod_status` still reflects the flag.
- R12: The priority order, from highest, is: line error, receive data, timeout, end of data, transmit empty, modem.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One pulse per 16x-bit-rate clock period |
| rx_char_stb | input | 1 | A character was received |
| rx_level | input | 6 | Receive FIFO fill level |
| tx_level | input | 6 | Transmit FIFO fill level |
| line_err | input | 4 | Line error flags of the current character |
| lsr_rd | input | 1 | Line status register is being read |
| modem_delta | input | 4 | Modem change flags (ring edge, DSR, DCD, CTS) |
| ier | input | 6 | Per-source interrupt enables |
| iir_rd | input | 1 | Identification register is being read |
| iir | output | 4 | {code[2:0], nothing-pending} |
| irq | output | 1 | Interrupt line |
| eod_status | output | 1 | End-of-data flag |

## Verification
The bench targets the boundary of the pause counter. End of data must still be absent a few ticks before 640 and present just after it. A counter that is off by a character time or that ignores `tick` would either fire early or stay silent through the tick-gated idle stretch. It also builds the misaligned-pause case. Here a design that ranked end of data above timeout would show code 4 while three bytes sit stranded, and one that failed to re-arm would never show end of data after the drain. Finally, it checks that reading `iir` clears end of data only while code 4 is presented, that a latched line error outranks every other source until the status read, and that each disabled source stays out of the code.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  typedef enum logic [2:0] {
    ID_MODEM = 3'd0,
    ID_TXE   = 3'd1,
    ID_RXD   = 3'd2,
    ID_LINE  = 3'd3,
    ID_EOD   = 3'd4,
    ID_TOUT  = 3'd6
  } irq_id_e;

  // enable bit positions in ier
  localparam int EN_RXD   = 0;
  localparam int EN_TXE   = 1;
  localparam int EN_LINE  = 2;
  localparam int EN_MODEM = 3;
  localparam int EN_TOUT  = 4;
  localparam int EN_EOD   = 5;
  localparam int NSRC     = 6;

  // priority slots, index 0 is the highest
  localparam int PR_LINE  = 0;
  localparam int PR_RXD   = 1;
  localparam int PR_TOUT  = 2;
  localparam int PR_EOD   = 3;
  localparam int PR_TXE   = 4;
  localparam int PR_MODEM = 5;

  function automatic irq_id_e id_of_slot(input int slot);
    case (slot)
      PR_LINE: return ID_LINE;
      PR_RXD:  return ID_RXD;
      PR_TOUT: return ID_TOUT;
      PR_EOD:  return ID_EOD;
      PR_TXE:  return ID_TXE;
      default: return ID_MODEM;
    endcase
  endfunction

endpackage

// File: rtl/uart_irq_pause_timer.sv
module uart_irq_pause_timer #(
  parameter int PAUSE_TICKS = 640
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic rx_char_stb,
  input  logic eod_clr,
  output logic idle_o,
  output logic eod_o
);
  localparam int CNT_W = $clog2(PAUSE_TICKS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PAUSE_TICKS - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             armed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      idle_o  <= 1'b0;
      armed_q <= 1'b0;
      eod_o   <= 1'b0;
    end else if (rx_char_stb) begin
      cnt_q   <= '0;
      idle_o  <= 1'b0;
      armed_q <= 1'b1;
      eod_o   <= 1'b0;
    end else begin
      if (eod_clr) eod_o <= 1'b0;
      if (tick && !idle_o) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == LAST) begin
          idle_o <= 1'b1;
          if (armed_q) begin
            eod_o   <= 1'b1;
            armed_q <= 1'b0;
          end
        end
      end
    end
  end

  // R8: a new character always withdraws end of data
  p_char_clears_eod_r8: assert property (@(posedge clk) disable iff (rst)
    rx_char_stb |=> !eod_o);

  // R6: end of data only appears on a tick with no character
  p_eod_on_tick_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(eod_o) |-> ($past(tick) && !$past(rx_char_stb)));

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] pend,
  output logic [3:0]      iir_q,
  output logic            irq_q
);
  irq_id_e sel_id;
  logic    any_pend;

  always_comb begin
    sel_id   = ID_MODEM;
    any_pend = |pend;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (pend[i]) sel_id = id_of_slot(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      iir_q <= 4'b0001;
      irq_q <= 1'b0;
    end else begin
      iir_q <= {sel_id, !any_pend};
      irq_q <= any_pend;
    end
  end

  // R2: line and identification never disagree
  p_irq_matches_r2: assert property (@(posedge clk) disable iff (rst)
    irq_q == !iir_q[0]);

  // R12: the top slot always wins
  p_line_wins_r12: assert property (@(posedge clk) disable iff (rst)
    pend[PR_LINE] |=> (iir_q[3:1] == ID_LINE));

  // R7: timeout pending hides end of data
  p_tout_before_eod_r7: assert property (@(posedge clk) disable iff (rst)
    pend[PR_TOUT] |=> (iir_q[3:1] != ID_EOD));

endmodule

// File: rtl/uart_rx_irq_ctrl.sv
module uart_rx_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int FIFO_DEPTH    = 32,
  parameter int RX_TRIG       = 4,
  parameter int TX_LWM        = 16,
  parameter int DMA_ALIGN     = 4,
  parameter int BITS_PER_CHAR = 10,
  parameter int OVERSAMPLE    = 16,
  parameter int PAUSE_CHARS   = 4,
  parameter int LERR_W        = 4,
  parameter int MDM_W         = 4,
  localparam int LVL_W        = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              rx_char_stb,
  input  logic [LVL_W-1:0]  rx_level,
  input  logic [LVL_W-1:0]  tx_level,
  input  logic [LERR_W-1:0] line_err,
  input  logic              lsr_rd,
  input  logic [MDM_W-1:0]  modem_delta,
  input  logic [NSRC-1:0]   ier,
  input  logic              iir_rd,
  output logic [3:0]        iir,
  output logic              irq,
  output logic              eod_status
);
  localparam int PAUSE_TICKS = PAUSE_CHARS * BITS_PER_CHAR * OVERSAMPLE;
  localparam int ALIGN_W     = (DMA_ALIGN > 1) ? $clog2(DMA_ALIGN) : 1;

  logic            line_q;
  logic            idle;
  logic            eod_flag;
  logic            eod_clr;
  logic            misaligned;
  logic [NSRC-1:0] pend;

  always_ff @(posedge clk) begin
    if (rst)                line_q <= 1'b0;
    else if (|line_err)     line_q <= 1'b1;
    else if (lsr_rd)        line_q <= 1'b0;
  end

  assign misaligned = (rx_level[ALIGN_W-1:0] != '0);
  assign eod_clr    = iir_rd && !iir[0] && (iir[3:1] == ID_EOD);

  uart_irq_pause_timer #(.PAUSE_TICKS(PAUSE_TICKS)) u_pause (
    .clk         (clk),
    .rst         (rst),
    .tick        (tick),
    .rx_char_stb (rx_char_stb),
    .eod_clr     (eod_clr),
    .idle_o      (idle),
    .eod_o       (eod_flag)
  );

  always_comb begin
    pend           = '0;
    pend[PR_LINE]  = ier[EN_LINE]  && line_q;
    pend[PR_RXD]   = ier[EN_RXD]   && (rx_level >= LVL_W'(RX_TRIG));
    pend[PR_TOUT]  = ier[EN_TOUT]  && idle && misaligned;
    pend[PR_EOD]   = ier[EN_EOD]   && eod_flag;
    pend[PR_TXE]   = ier[EN_TXE]   && (tx_level <= LVL_W'(TX_LWM));
    pend[PR_MODEM] = ier[EN_MODEM] && (|modem_delta);
  end

  uart_irq_prio u_prio (
    .clk   (clk),
    .rst   (rst),
    .pend  (pend),
    .iir_q (iir),
    .irq_q (irq)
  );

  assign eod_status = eod_flag;

  // R3: status read with no new error drops the latch
  p_lsr_clears_r3: assert property (@(posedge clk) disable iff (rst)
    (lsr_rd && !(|line_err)) |=> !line_q);

  // R3: new error always latches
  p_err_latches_r3: assert property (@(posedge clk) disable iff (rst)
    (|line_err) |=> line_q);

  // R11: end of data shown only if enabled one cycle earlier
  p_eod_enabled_r11: assert property (@(posedge clk) disable iff (rst)
    (!iir[0] && iir[3:1] == ID_EOD) |-> $past(ier[EN_EOD]));

  // R8: identification read of end of data withdraws it
  p_iir_rd_clears_r8: assert property (@(posedge clk) disable iff (rst)
    eod_clr |=> !eod_status);

endmodule

// File: tb/uart_rx_irq_ctrl_tb.sv
module uart_rx_irq_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b1;
  logic       rx_char_stb = 1'b0;
  logic [5:0] rx_level = '0;
  logic [5:0] tx_level = 6'd20;
  logic [3:0] line_err = '0;
  logic       lsr_rd = 1'b0;
  logic [3:0] modem_delta = '0;
  logic [5:0] ier = '0;
  logic       iir_rd = 1'b0;
  logic [3:0] iir;
  logic       irq;
  logic       eod_status;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  uart_rx_irq_ctrl u_dut (
    .clk(clk), .rst(rst), .tick(tick), .rx_char_stb(rx_char_stb),
    .rx_level(rx_level), .tx_level(tx_level), .line_err(line_err),
    .lsr_rd(lsr_rd), .modem_delta(modem_delta), .ier(ier),
    .iir_rd(iir_rd), .iir(iir), .irq(irq), .eod_status(eod_status)
  );

  // vector: {ier[5:0], rx_level[5:0], tx_level[5:0], modem[3:0], exp_iir[3:0]}
  localparam int NV = 10;
  localparam logic [25:0] TBL [NV] = '{
    {6'h3F, 6'd0,  6'd20, 4'h0, 4'b0001},  // R2 nothing pending
    {6'h3F, 6'd4,  6'd20, 4'h0, 4'b0100},  // R4 trigger boundary
    {6'h3F, 6'd0,  6'd16, 4'h0, 4'b0010},  // R9 watermark boundary
    {6'h3F, 6'd0,  6'd20, 4'h1, 4'b0000},  // R10 modem
    {6'h3F, 6'd8,  6'd5,  4'h4, 4'b0100},  // R12 rxd over txe/modem
    {6'h3F, 6'd0,  6'd5,  4'h8, 4'b0010},  // R12 txe over modem
    {6'h3E, 6'd8,  6'd5,  4'h0, 4'b0010},  // R11 rxd disabled
    {6'h08, 6'd8,  6'd5,  4'h2, 4'b0000},  // R11 modem only
    {6'h00, 6'd8,  6'd0,  4'hF, 4'b0001},  // R11 all disabled
    {6'h3F, 6'd0,  6'd17, 4'h0, 4'b0001}   // R9 above watermark
  };

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pulse_char(input logic [5:0] lvl);
    rx_char_stb = 1'b1;
    rx_level = lvl;
    step(1);
    rx_char_stb = 1'b0;
  endtask

  initial begin
    #1500000;
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    step(3);
    chk("R1 iir", iir, 4'b0001);
    chk("R1 irq", irq, 0);
    chk("R1 eod", eod_status, 0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      ier = TBL[i][25:20];
      rx_level = TBL[i][19:14];
      tx_level = TBL[i][13:8];
      modem_delta = TBL[i][7:4];
      step(3);
      chk("R2/R12 table iir", iir, TBL[i][3:0]);
      chk("R2 table irq", irq, !TBL[i][0]);
    end

    // R3 line error latch and priority
    ier = 6'h3F; rx_level = 6'd4; tx_level = 6'd20; modem_delta = '0;
    line_err = 4'b0010; step(1); line_err = '0; step(3);
    chk("R3 line shown", iir, 4'b0110);
    step(5);
    chk("R3 line held", iir, 4'b0110);
    lsr_rd = 1'b1; step(1); lsr_rd = 1'b0; step(3);
    chk("R3 cleared by status read", iir, 4'b0100);
    ier = 6'h3B;
    line_err = 4'b1000; step(1); line_err = '0; step(3);
    chk("R11 line disabled", iir, 4'b0100);
    ier = 6'h3F; step(3);
    chk("R3 latched while disabled", iir, 4'b0110);
    lsr_rd = 1'b1; step(1); lsr_rd = 1'b0;

    // R5 R6 R7 misaligned pause
    rx_level = 6'd0; step(2);
    pulse_char(6'd3);
    step(628);
    chk("R6 no eod before 640 ticks", eod_status, 0);
    chk("R5 no timeout before idle", iir, 4'b0001);
    step(14);
    chk("R6 eod after pause", eod_status, 1);
    chk("R7 timeout presented first", iir, 4'b1100);
    iir_rd = 1'b1; step(1); iir_rd = 1'b0; step(2);
    chk("R8 read during timeout keeps eod", eod_status, 1);
    rx_level = 6'd0; step(3);
    chk("R5/R7 eod after drain", iir, 4'b1000);
    iir_rd = 1'b1; step(1); iir_rd = 1'b0; step(3);
    chk("R8 read clears eod", eod_status, 0);
    chk("R8 iir after clear", iir, 4'b0001);
    step(700);
    chk("R6 no refire without char", eod_status, 0);

    // R8 char clears eod; aligned pause gives eod only
    pulse_char(6'd0);
    step(645);
    chk("R6 aligned pause eod", iir, 4'b1000);
    pulse_char(6'd0);
    step(3);
    chk("R8 char clears eod", eod_status, 0);
    chk("R8 iir after char", iir, 4'b0001);

    // R6 only ticks advance the counter
    tick = 1'b0;
    step(900);
    chk("R6 no eod without ticks", eod_status, 0);
    tick = 1'b1;
    step(645);
    chk("R6 eod once ticks resume", eod_status, 1);

    // R11 eod disabled: flag visible, no interrupt
    ier = 6'h1F; step(3);
    chk("R11 eod hidden", iir, 4'b0001);
    chk("R11 irq low", irq, 0);
    chk("R11 flag kept", eod_status, 1);

    // R1 reset mid-run
    rst = 1'b1; step(2);
    chk("R1 reset iir", iir, 4'b0001);
    chk("R1 reset eod", eod_status, 0);
    rst = 1'b0;

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule